// File: doc/BRIEF.md
# Coprocessor Offload Functional Unit

This execute-stage functional unit passes instructions that the core's own decoder did not recognise to an external coprocessor. Three handshake channels are used. The issue channel carries the raw instruction word, its 3-bit transaction id (the scoreboard slot of the instruction) and two or three source operands. The commit channel confirms every issued instruction unconditionally. The result channel returns the outcome of accepted instructions, possibly out of order, onto the unit's single writeback port.

When the coprocessor refuses an instruction, the unit raises an illegal-instruction exception (cause 2) on writeback itself, with the instruction word as the trap value. Coprocessor results use the same writeback port and always win it. A refusal that meets a result in the same cycle is therefore parked in a holding stage of three registers (id, cause, instruction word). It is emitted on the first cycle in which no result is present. While the holding stage is full, no new instruction is offered, so a second refusal can never overwrite a parked one. A flush empties the holding stage.

Top module: `cpx_offload_unit`

## Requirements
- R1: The issue request copies the functional-unit id, the instruction word and each operand slot k (bits k*XLEN upward of the flat operand bus) unchanged. Every per-operand valid bit is 1. The operand count NUM_SRC is 2 or 3.
- R2: The commit valid equals the issue valid and the commit id equals the issue id. The commit kill bit is always 0.
- R3: The result-channel ready output is 1 in every cycle.
- R4: A valid result appears on writeback in the same cycle. Its valid, id and data are copied, the exception flag and cause are copied, and the trap value is 0.
- R5: An issue handshake (valid and ready both high) with accept low, in a cycle with no result, produces a writeback in that cycle with the exception flag set, cause 2, the instruction's id, the instruction word as trap value, and data 0.
- R6: An issue handshake with accept high produces no writeback of its own.
- R7: A rejected handshake that coincides with a valid result is parked. The result is written back first. The illegal-instruction exception appears on the first later cycle in which no result is valid, however many result cycles come in between.
- R8: While an exception is parked, issue valid and the functional-unit ready are both 0. Otherwise the functional-unit ready equals the coprocessor's issue ready, and issue valid equals the functional-unit valid.
- R9: A flush empties the holding stage. A parked exception is never written back after a flush.
- R10: The writeback register-write enable is 0 in any cycle whose exception flag is 1.
- R11: After reset, with all inputs low, writeback valid is 0 and nothing is parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Discard any parked exception |
| fu_valid_i | input | 1 | Instruction offered by the issue stage |
| fu_id_i | input | ID_W | Scoreboard id of the offered instruction |
| fu_ops_i | input | NUM_SRC*XLEN | Source operands, slot k at bits k*XLEN |
| fu_insn_i | input | INSN_W | Undecoded instruction word |
| fu_ready_o | output | 1 | Unit can take the offered instruction |
| issue_valid_o | output | 1 | Issue request valid |
| issue_ready_i | input | 1 | Coprocessor ready on issue |
| issue_accept_i | input | 1 | Coprocessor accepts the instruction |
| issue_id_o | output | ID_W | Issue transaction id |
| issue_ops_o | output | NUM_SRC*XLEN | Issued operands |
| issue_opvalid_o | output | NUM_SRC | Per-operand valid bits |
| issue_insn_o | output | INSN_W | Issued instruction word |
| commit_valid_o | output | 1 | Commit valid |
| commit_id_o | output | ID_W | Commit transaction id |
| commit_kill_o | output | 1 | Commit kill bit |
| res_valid_i | input | 1 | Coprocessor result valid |
| res_ready_o | output | 1 | Result ready |
| res_id_i | input | ID_W | Result transaction id |
| res_data_i | input | XLEN | Result data |
| res_we_i | input | 1 | Result writes the destination register |
| res_exc_i | input | 1 | Coprocessor reports an exception |
| res_cause_i | input | CAUSE_W | Coprocessor exception cause |
| wb_valid_o | output | 1 | Writeback valid |
| wb_id_o | output | ID_W | Writeback scoreboard id |
| wb_data_o | output | XLEN | Writeback data |
| wb_we_o | output | 1 | Register-file write enable |
| wb_exc_o | output | 1 | Writeback carries an exception |
| wb_cause_o | output | CAUSE_W | Exception cause |
| wb_tval_o | output | XLEN | Exception trap value |

## Verification
Coprocessor results, direct rejections and the issue and commit mirrors are all combinational, so each is due in the same cycle as its stimulus. The bench drives inputs on the falling clock edge and samples them 1 ns later, before the next rising edge. A parked exception is due in the first cycle after the collision in which the result valid is low. The directed tests therefore hold the result valid high for an extra cycle and check that writeback is still busy and issue is blocked. They then check the exception in the cycle that follows. Flush behaviour is checked in the flush cycle itself and again one rising edge later, when the holding stage must already be empty.

// File: rtl/cpx_pkg.sv
`timescale 1ns/1ps
package cpx_pkg;
  localparam int unsigned CAUSE_ILLEGAL_INSN = 2;

  typedef enum logic [1:0] {
    WB_IDLE   = 2'd0,
    WB_RESULT = 2'd1,
    WB_PARKED = 2'd2,
    WB_DIRECT = 2'd3
  } wb_src_e;
endpackage

// File: rtl/cpx_issue_ctrl.sv
`timescale 1ns/1ps
module cpx_issue_ctrl #(
  parameter int unsigned ID_W    = 3,
  parameter int unsigned XLEN    = 32,
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned INSN_W  = 32
) (
  input  logic                    fu_valid_i,
  input  logic [ID_W-1:0]         fu_id_i,
  input  logic [NUM_SRC*XLEN-1:0] fu_ops_i,
  input  logic [INSN_W-1:0]       fu_insn_i,
  input  logic                    park_busy_i,
  input  logic                    issue_ready_i,
  input  logic                    issue_accept_i,
  output logic                    fu_ready_o,
  output logic                    issue_valid_o,
  output logic [ID_W-1:0]         issue_id_o,
  output logic [NUM_SRC*XLEN-1:0] issue_ops_o,
  output logic [NUM_SRC-1:0]      issue_opvalid_o,
  output logic [INSN_W-1:0]       issue_insn_o,
  output logic                    commit_valid_o,
  output logic [ID_W-1:0]         commit_id_o,
  output logic                    commit_kill_o,
  output logic                    reject_o
);
  logic fire;

  // A parked refusal blocks new offers so it cannot be overwritten.
  assign issue_valid_o = fu_valid_i && !park_busy_i;
  assign fu_ready_o    = issue_ready_i && !park_busy_i;
  assign issue_id_o    = fu_id_i;
  assign issue_insn_o  = fu_insn_i;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_slot
    assign issue_ops_o[k*XLEN +: XLEN] = fu_ops_i[k*XLEN +: XLEN];
    assign issue_opvalid_o[k]          = 1'b1;
  end

  assign commit_valid_o = issue_valid_o;
  assign commit_id_o    = fu_id_i;
  assign commit_kill_o  = 1'b0;

  assign fire     = issue_valid_o && issue_ready_i;
  assign reject_o = fire && !issue_accept_i;
endmodule

// File: rtl/cpx_park_regs.sv
`timescale 1ns/1ps
module cpx_park_regs #(
  parameter int unsigned ID_W    = 3,
  parameter int unsigned INSN_W  = 32,
  parameter int unsigned CAUSE_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               capture_i,
  input  logic               release_i,
  input  logic [ID_W-1:0]    id_i,
  input  logic [INSN_W-1:0]  insn_i,
  output logic               busy_o,
  output logic [ID_W-1:0]    id_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [INSN_W-1:0]  insn_o
);
  logic               busy_q;
  logic [ID_W-1:0]    id_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [INSN_W-1:0]  insn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      id_q    <= '0;
      cause_q <= '0;
      insn_q  <= '0;
    end else if (flush_i) begin
      busy_q  <= 1'b0;
      id_q    <= '0;
      cause_q <= '0;
      insn_q  <= '0;
    end else if (capture_i) begin
      busy_q  <= 1'b1;
      id_q    <= id_i;
      cause_q <= CAUSE_W'(cpx_pkg::CAUSE_ILLEGAL_INSN);
      insn_q  <= insn_i;
    end else if (release_i) begin
      busy_q  <= 1'b0;
    end
  end

  assign busy_o  = busy_q;
  assign id_o    = id_q;
  assign cause_o = cause_q;
  assign insn_o  = insn_q;
endmodule

// File: rtl/cpx_wb_arb.sv
`timescale 1ns/1ps
module cpx_wb_arb #(
  parameter int unsigned ID_W    = 3,
  parameter int unsigned XLEN    = 32,
  parameter int unsigned INSN_W  = 32,
  parameter int unsigned CAUSE_W = 6
) (
  input  logic               flush_i,
  input  logic               reject_i,
  input  logic [ID_W-1:0]    fu_id_i,
  input  logic [INSN_W-1:0]  fu_insn_i,
  input  logic               res_valid_i,
  input  logic [ID_W-1:0]    res_id_i,
  input  logic [XLEN-1:0]    res_data_i,
  input  logic               res_we_i,
  input  logic               res_exc_i,
  input  logic [CAUSE_W-1:0] res_cause_i,
  input  logic               park_busy_i,
  input  logic [ID_W-1:0]    park_id_i,
  input  logic [CAUSE_W-1:0] park_cause_i,
  input  logic [INSN_W-1:0]  park_insn_i,
  output logic               capture_o,
  output logic               release_o,
  output cpx_pkg::wb_src_e   src_o,
  output logic               wb_valid_o,
  output logic [ID_W-1:0]    wb_id_o,
  output logic [XLEN-1:0]    wb_data_o,
  output logic               wb_we_o,
  output logic               wb_exc_o,
  output logic [CAUSE_W-1:0] wb_cause_o,
  output logic [XLEN-1:0]    wb_tval_o
);
  localparam int unsigned TV_W = (INSN_W < XLEN) ? INSN_W : XLEN;

  function automatic logic [XLEN-1:0] insn_to_tval(input logic [INSN_W-1:0] insn);
    logic [XLEN-1:0] t;
    t = '0;
    t[TV_W-1:0] = insn[TV_W-1:0];
    return t;
  endfunction

  // Results own the port; a parked refusal beats a fresh one.
  always_comb begin
    if (res_valid_i)                     src_o = cpx_pkg::WB_RESULT;
    else if (park_busy_i && !flush_i)    src_o = cpx_pkg::WB_PARKED;
    else if (reject_i)                   src_o = cpx_pkg::WB_DIRECT;
    else                                 src_o = cpx_pkg::WB_IDLE;
  end

  assign capture_o = reject_i && res_valid_i && !flush_i;
  assign release_o = (src_o == cpx_pkg::WB_PARKED);

  always_comb begin
    wb_valid_o = 1'b0;
    wb_id_o    = '0;
    wb_data_o  = '0;
    wb_we_o    = 1'b0;
    wb_exc_o   = 1'b0;
    wb_cause_o = '0;
    wb_tval_o  = '0;
    unique case (src_o)
      cpx_pkg::WB_RESULT: begin
        wb_valid_o = 1'b1;
        wb_id_o    = res_id_i;
        wb_data_o  = res_data_i;
        wb_we_o    = res_we_i && !res_exc_i;
        wb_exc_o   = res_exc_i;
        wb_cause_o = res_cause_i;
      end
      cpx_pkg::WB_PARKED: begin
        wb_valid_o = 1'b1;
        wb_id_o    = park_id_i;
        wb_exc_o   = 1'b1;
        wb_cause_o = park_cause_i;
        wb_tval_o  = insn_to_tval(park_insn_i);
      end
      cpx_pkg::WB_DIRECT: begin
        wb_valid_o = 1'b1;
        wb_id_o    = fu_id_i;
        wb_exc_o   = 1'b1;
        wb_cause_o = CAUSE_W'(cpx_pkg::CAUSE_ILLEGAL_INSN);
        wb_tval_o  = insn_to_tval(fu_insn_i);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cpx_offload_unit.sv
`timescale 1ns/1ps
module cpx_offload_unit #(
  parameter int unsigned ID_W    = 3,
  parameter int unsigned XLEN    = 32,
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned INSN_W  = 32,
  parameter int unsigned CAUSE_W = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic                    fu_valid_i,
  input  logic [ID_W-1:0]         fu_id_i,
  input  logic [NUM_SRC*XLEN-1:0] fu_ops_i,
  input  logic [INSN_W-1:0]       fu_insn_i,
  output logic                    fu_ready_o,
  output logic                    issue_valid_o,
  input  logic                    issue_ready_i,
  input  logic                    issue_accept_i,
  output logic [ID_W-1:0]         issue_id_o,
  output logic [NUM_SRC*XLEN-1:0] issue_ops_o,
  output logic [NUM_SRC-1:0]      issue_opvalid_o,
  output logic [INSN_W-1:0]       issue_insn_o,
  output logic                    commit_valid_o,
  output logic [ID_W-1:0]         commit_id_o,
  output logic                    commit_kill_o,
  input  logic                    res_valid_i,
  output logic                    res_ready_o,
  input  logic [ID_W-1:0]         res_id_i,
  input  logic [XLEN-1:0]         res_data_i,
  input  logic                    res_we_i,
  input  logic                    res_exc_i,
  input  logic [CAUSE_W-1:0]      res_cause_i,
  output logic                    wb_valid_o,
  output logic [ID_W-1:0]         wb_id_o,
  output logic [XLEN-1:0]         wb_data_o,
  output logic                    wb_we_o,
  output logic                    wb_exc_o,
  output logic [CAUSE_W-1:0]      wb_cause_o,
  output logic [XLEN-1:0]         wb_tval_o
);
  // Named internal events for the checker.
  logic               reject_now;
  logic               park_busy;
  logic               park_capture;
  logic               park_release;
  logic [ID_W-1:0]    park_id;
  logic [CAUSE_W-1:0] park_cause;
  logic [INSN_W-1:0]  park_insn;
  cpx_pkg::wb_src_e   wb_src;

  assign res_ready_o = 1'b1;

  cpx_issue_ctrl #(
    .ID_W(ID_W), .XLEN(XLEN), .NUM_SRC(NUM_SRC), .INSN_W(INSN_W)
  ) i_issue (
    .fu_valid_i      (fu_valid_i),
    .fu_id_i         (fu_id_i),
    .fu_ops_i        (fu_ops_i),
    .fu_insn_i       (fu_insn_i),
    .park_busy_i     (park_busy),
    .issue_ready_i   (issue_ready_i),
    .issue_accept_i  (issue_accept_i),
    .fu_ready_o      (fu_ready_o),
    .issue_valid_o   (issue_valid_o),
    .issue_id_o      (issue_id_o),
    .issue_ops_o     (issue_ops_o),
    .issue_opvalid_o (issue_opvalid_o),
    .issue_insn_o    (issue_insn_o),
    .commit_valid_o  (commit_valid_o),
    .commit_id_o     (commit_id_o),
    .commit_kill_o   (commit_kill_o),
    .reject_o        (reject_now)
  );

  cpx_park_regs #(
    .ID_W(ID_W), .INSN_W(INSN_W), .CAUSE_W(CAUSE_W)
  ) i_park (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .capture_i (park_capture),
    .release_i (park_release),
    .id_i      (fu_id_i),
    .insn_i    (fu_insn_i),
    .busy_o    (park_busy),
    .id_o      (park_id),
    .cause_o   (park_cause),
    .insn_o    (park_insn)
  );

  cpx_wb_arb #(
    .ID_W(ID_W), .XLEN(XLEN), .INSN_W(INSN_W), .CAUSE_W(CAUSE_W)
  ) i_arb (
    .flush_i      (flush_i),
    .reject_i     (reject_now),
    .fu_id_i      (fu_id_i),
    .fu_insn_i    (fu_insn_i),
    .res_valid_i  (res_valid_i),
    .res_id_i     (res_id_i),
    .res_data_i   (res_data_i),
    .res_we_i     (res_we_i),
    .res_exc_i    (res_exc_i),
    .res_cause_i  (res_cause_i),
    .park_busy_i  (park_busy),
    .park_id_i    (park_id),
    .park_cause_i (park_cause),
    .park_insn_i  (park_insn),
    .capture_o    (park_capture),
    .release_o    (park_release),
    .src_o        (wb_src),
    .wb_valid_o   (wb_valid_o),
    .wb_id_o      (wb_id_o),
    .wb_data_o    (wb_data_o),
    .wb_we_o      (wb_we_o),
    .wb_exc_o     (wb_exc_o),
    .wb_cause_o   (wb_cause_o),
    .wb_tval_o    (wb_tval_o)
  );
endmodule

// File: rtl/cpx_offload_chk.sv
`timescale 1ns/1ps
module cpx_offload_chk #(
  parameter int unsigned ID_W    = 3,
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned CAUSE_W = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               flush_i,
  input logic               fu_valid_i,
  input logic               fu_ready_o,
  input logic               issue_valid_o,
  input logic [ID_W-1:0]    issue_id_o,
  input logic [NUM_SRC-1:0] issue_opvalid_o,
  input logic               commit_valid_o,
  input logic [ID_W-1:0]    commit_id_o,
  input logic               commit_kill_o,
  input logic               res_valid_i,
  input logic               res_ready_o,
  input logic [ID_W-1:0]    res_id_i,
  input logic               wb_valid_o,
  input logic [ID_W-1:0]    wb_id_o,
  input logic               wb_we_o,
  input logic               wb_exc_o,
  input logic [CAUSE_W-1:0] wb_cause_o,
  input logic               park_busy,
  input logic               park_capture
);
  a_r1_opvalid_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> (issue_opvalid_o == {NUM_SRC{1'b1}}));

  a_r2_commit_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_valid_o == issue_valid_o) && (commit_id_o == issue_id_o) && !commit_kill_o);

  a_r3_res_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_ready_o);

  a_r4_result_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |-> (wb_valid_o && wb_id_o == res_id_i));

  a_r7_parked_emits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (park_busy && !res_valid_i && !flush_i) |->
      (wb_valid_o && wb_exc_o && wb_cause_o == CAUSE_W'(2)));

  a_r7_capture_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    park_capture |=> park_busy);

  a_r8_block_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    park_busy |-> (!issue_valid_o && !fu_ready_o));

  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !park_busy);

  a_r10_no_we_on_exc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_exc_o |-> !wb_we_o);

  a_r8_offer_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!park_busy && fu_valid_i) |-> issue_valid_o);
endmodule

bind cpx_offload_unit cpx_offload_chk #(
  .ID_W(ID_W), .NUM_SRC(NUM_SRC), .CAUSE_W(CAUSE_W)
) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .flush_i         (flush_i),
  .fu_valid_i      (fu_valid_i),
  .fu_ready_o      (fu_ready_o),
  .issue_valid_o   (issue_valid_o),
  .issue_id_o      (issue_id_o),
  .issue_opvalid_o (issue_opvalid_o),
  .commit_valid_o  (commit_valid_o),
  .commit_id_o     (commit_id_o),
  .commit_kill_o   (commit_kill_o),
  .res_valid_i     (res_valid_i),
  .res_ready_o     (res_ready_o),
  .res_id_i        (res_id_i),
  .wb_valid_o      (wb_valid_o),
  .wb_id_o         (wb_id_o),
  .wb_we_o         (wb_we_o),
  .wb_exc_o        (wb_exc_o),
  .wb_cause_o      (wb_cause_o),
  .park_busy       (park_busy),
  .park_capture    (park_capture)
);

// File: tb/test_cpx_offload_unit.sv
`timescale 1ns/1ps
module test_cpx_offload_unit;
  localparam int IDW = 3;
  localparam int XL  = 32;
  localparam int NS  = 3;
  localparam int IW  = 32;
  localparam int CW  = 6;
  localparam int NVEC = 8;

  // {fu_valid, fu_id[3], ready, accept, res_valid, res_id[3], res_exc}
  localparam logic [10:0] VEC [NVEC] = '{
    11'b1_001_1_1_0_000_0,  // accepted, no result (R6)
    11'b1_010_1_0_0_000_0,  // rejected, port free (R5)
    11'b0_011_1_0_1_100_0,  // plain result (R4)
    11'b1_110_1_1_1_111_1,  // accepted + result with exception (R4, R10)
    11'b1_000_0_0_0_000_0,  // no handshake, ready low
    11'b0_000_0_0_0_000_0,  // idle
    11'b1_111_1_0_0_000_0,  // rejected id 7 (R5)
    11'b1_101_0_0_1_001_0   // result while coprocessor not ready
  };

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic fu_valid = 1'b0; logic [IDW-1:0] fu_id = '0;
  logic [NS*XL-1:0] fu_ops = '0; logic [IW-1:0] fu_insn = '0;
  logic issue_ready = 1'b0, issue_accept = 1'b0;
  logic res_valid = 1'b0, res_we = 1'b0, res_exc = 1'b0;
  logic [IDW-1:0] res_id = '0; logic [XL-1:0] res_data = '0; logic [CW-1:0] res_cause = '0;
  logic fu_ready, issue_valid, commit_valid, commit_kill, res_ready;
  logic [IDW-1:0] issue_id, commit_id, wb_id;
  logic [NS*XL-1:0] issue_ops; logic [NS-1:0] issue_opvalid; logic [IW-1:0] issue_insn;
  logic wb_valid, wb_we, wb_exc; logic [XL-1:0] wb_data, wb_tval; logic [CW-1:0] wb_cause;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  cpx_offload_unit #(.ID_W(IDW), .XLEN(XL), .NUM_SRC(NS), .INSN_W(IW), .CAUSE_W(CW))
  i_cpx_offload_unit (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .fu_valid_i(fu_valid), .fu_id_i(fu_id), .fu_ops_i(fu_ops), .fu_insn_i(fu_insn),
    .fu_ready_o(fu_ready), .issue_valid_o(issue_valid), .issue_ready_i(issue_ready),
    .issue_accept_i(issue_accept), .issue_id_o(issue_id), .issue_ops_o(issue_ops),
    .issue_opvalid_o(issue_opvalid), .issue_insn_o(issue_insn),
    .commit_valid_o(commit_valid), .commit_id_o(commit_id), .commit_kill_o(commit_kill),
    .res_valid_i(res_valid), .res_ready_o(res_ready), .res_id_i(res_id),
    .res_data_i(res_data), .res_we_i(res_we), .res_exc_i(res_exc), .res_cause_i(res_cause),
    .wb_valid_o(wb_valid), .wb_id_o(wb_id), .wb_data_o(wb_data), .wb_we_o(wb_we),
    .wb_exc_o(wb_exc), .wb_cause_o(wb_cause), .wb_tval_o(wb_tval)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    fu_valid = 0; issue_ready = 1; issue_accept = 0; res_valid = 0;
    res_exc = 0; res_we = 0; flush = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    idle_inputs();
    rst_n = 1;
    #1;
    // R11 reset state
    chk(wb_valid == 1'b0, "R11", wb_valid, 0);
    chk(fu_ready == 1'b1, "R11", fu_ready, 1);
    chk(res_ready == 1'b1, "R3", res_ready, 1);

    for (int i = 0; i < NVEC; i++) begin
      logic [10:0] v;
      logic ev, ee; logic [IDW-1:0] eid;
      v = VEC[i];
      @(negedge clk);
      fu_valid = v[10]; fu_id = v[9:7]; issue_ready = v[6]; issue_accept = v[5];
      res_valid = v[4]; res_id = v[3:1]; res_exc = v[0];
      res_we = 1'b1; res_cause = CW'(i + 8); res_data = 32'hA500_0000 + XL'(i);
      fu_insn = 32'h0000_000B | (IW'(i) << 12);
      for (int k = 0; k < NS; k++) fu_ops[k*XL +: XL] = 32'h1000_0000 * (k + 1) + XL'(i);
      #1;
      // independent model of the expected writeback
      ev = 0; ee = 0; eid = '0;
      if (v[4]) begin ev = 1; ee = v[0]; eid = v[3:1]; end
      else if (v[10] && v[6] && !v[5]) begin ev = 1; ee = 1; eid = v[9:7]; end
      chk(issue_valid == v[10], "R8", issue_valid, v[10]);
      chk(fu_ready == v[6], "R8", fu_ready, v[6]);
      chk(issue_id == fu_id && issue_insn == fu_insn, "R1", {issue_id, issue_insn}, {fu_id, fu_insn});
      chk(issue_ops == fu_ops && issue_opvalid == '1, "R1", issue_ops, fu_ops);
      chk(commit_valid == v[10] && commit_id == fu_id && !commit_kill, "R2",
          {commit_valid, commit_id, commit_kill}, {v[10], fu_id, 1'b0});
      chk(wb_valid == ev, (v[10] && v[5]) ? "R6" : "R5", wb_valid, ev);
      if (ev) begin
        chk(wb_id == eid && wb_exc == ee, "R4", {wb_id, wb_exc}, {eid, ee});
        if (v[4]) begin
          chk(wb_data == res_data && wb_cause == res_cause && wb_tval == '0, "R4",
              {wb_data, wb_cause, wb_tval}, {res_data, res_cause, 32'h0});
          chk(wb_we == !v[0], "R10", wb_we, !v[0]);
        end else begin
          chk(wb_cause == CW'(2) && wb_tval == fu_insn && wb_data == '0 && !wb_we, "R5",
              {wb_cause, wb_tval, wb_we}, {CW'(2), fu_insn, 1'b0});
        end
      end
    end

    // R7: collision, result first, exception after two result cycles
    @(negedge clk);
    idle_inputs();
    fu_valid = 1; fu_id = 3'd5; fu_insn = 32'hDEAD_B00B; issue_accept = 0;
    res_valid = 1; res_id = 3'd2; res_data = 32'h1234_5678; res_we = 1;
    #1;
    chk(wb_valid && wb_id == 3'd2 && !wb_exc && wb_data == 32'h1234_5678, "R7",
        {wb_valid, wb_id, wb_exc}, {1'b1, 3'd2, 1'b0});
    @(negedge clk);
    fu_insn = 32'h0; fu_id = 3'd1; res_id = 3'd3;
    #1;
    chk(wb_valid && wb_id == 3'd3 && !wb_exc, "R7", {wb_id, wb_exc}, {3'd3, 1'b0});
    chk(!issue_valid && !fu_ready, "R8", {issue_valid, fu_ready}, 2'b00);
    @(negedge clk);
    res_valid = 0; fu_valid = 0;
    #1;
    chk(wb_valid && wb_exc && wb_id == 3'd5 && wb_cause == CW'(2) && wb_tval == 32'hDEAD_B00B && !wb_we,
        "R7", {wb_valid, wb_exc, wb_id, wb_tval}, {1'b1, 1'b1, 3'd5, 32'hDEAD_B00B});
    @(negedge clk);
    #1;
    chk(!wb_valid && fu_ready, "R7", {wb_valid, fu_ready}, 2'b01);

    // R9: flush discards a parked exception
    @(negedge clk);
    fu_valid = 1; fu_id = 3'd6; fu_insn = 32'hCAFE_000B; issue_accept = 0;
    res_valid = 1; res_id = 3'd4;
    @(negedge clk);
    fu_valid = 0; res_valid = 0; flush = 1;
    #1;
    chk(!wb_valid, "R9", wb_valid, 0);
    @(negedge clk);
    flush = 0;
    #1;
    chk(!wb_valid && fu_ready, "R9", {wb_valid, fu_ready}, 2'b01);
    @(negedge clk);
    #1;
    chk(!wb_valid, "R9", wb_valid, 0);

    finish_run();
  end
endmodule